// File: doc/BRIEF.md
# Transport Stream PID Filter

The block sits in the receive path of an MPEG transport stream and keeps only the packets that software asks for. Bytes arrive one per cycle with a valid flag and a start flag on the first byte of each 188-byte packet. The 13-bit packet identifier is read from bytes 1 and 2 and compared against a bank of programmable match slots. A packet is then forwarded whole or dropped whole. Accepted packets leave as 32-bit words, four stream bytes per word, with a valid flag and a start flag on the first word.

Slot 0 also carries three global controls. One forwards every packet. One blocks every packet. One selects the byte order inside the output words. Configuration is a plain write/read port, with one 32-bit word per slot at byte offset `4*slot`. Writes land in a shadow copy. The filter works from an active copy that is refreshed only when a new packet starts, so a packet is always judged and packed under one consistent setting.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset every slot reads back 0x0000_1FFF: PID 0x1FFF, enable clear, all global controls clear. No packet is forwarded until a slot is enabled.
- R2: The slot is selected by byte address bits [4:2]; address bits [1:0] are ignored. In every slot, bits 12:0 hold the PID and bit 15 is the enable. Slot 0 adds bit 13 (block all), bit 14 (byte order) and bit 16 (forward all). Every other bit reads back as zero.
- R3: A packet is forwarded when at least one slot has its enable bit set and its PID equal to the packet PID. The packet PID is {byte1[4:0], byte2}.
- R4: A slot with its enable bit clear matches nothing, whatever its PID field holds. This includes the parked value 0x1FFF.
- R5: When slot 0 bit 16 is set, every packet with a correct sync byte is forwarded, even if slot 0 bit 13 is also set.
- R6: When slot 0 bit 13 is set and bit 16 is clear, no packet is forwarded, even if it matches a slot.
- R7: A packet whose first byte is not 0x47 is dropped whole, whatever the control bits say.
- R8: A configuration write takes effect from the next packet start. It does not change whether the packet in flight is forwarded, nor its byte order.
- R9: A forwarded packet appears as 47 words. Word k holds packet bytes 4k..4k+3, and the start flag is set on word 0 only. With slot 0 bit 14 clear, byte 4k sits in bits 31:24 and byte 4k+3 in bits 7:0. With the bit set, byte 4k sits in bits 7:0 and byte 4k+3 in bits 31:24.
- R10: Word k is presented for exactly one cycle: the cycle after the clock edge that takes in byte 4k+3. In every other cycle the output valid flag is low.
- R11: Cycles with the input valid flag low are ignored, as is their start flag. So are valid bytes that arrive outside a packet, meaning before any start flag or after the 188th byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is present this cycle |
| in_sop | input | 1 | Input byte is the first byte of a packet |
| in_data | input | 8 | Input stream byte |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | CFG_AW (5) | Byte address of the slot word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Written (shadow) value of the addressed slot |
| out_valid | output | 1 | Output word is present this cycle |
| out_sop | output | 1 | Output word is the first word of a packet |
| out_word | output | 32 | Four packed bytes of an accepted packet |

## Verification
The bench sweeps the packet PID around every programmed slot value, one above and one below, under both byte orders. A comparator that is off by one bit, or a slot decoder that is shifted, therefore shows up as a wrong pass or a wrong drop. It sets the forward-all and block-all controls on their own and together, and it sends bad sync bytes with forward-all set. A design with the priority backwards would block or leak whole packets. It issues writes in the middle of a packet that change block-all, byte order and a slot PID. A design without the packet-boundary latch would cut the packet short, emit it in mixed byte order, or judge it with the new setting. Every output cycle is compared against the expected word, so a lane slip, a missing start flag, or a word emitted during an input gap or for stray bytes between packets counts as a failure.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    localparam int PKT_BYTES = 188;
    localparam logic [7:0] SYNC_BYTE = 8'h47;
    localparam int PID_W = 13;

    // Fixed bit positions inside a slot word
    localparam int BIT_BLOCK = 13;
    localparam int BIT_ORDER = 14;
    localparam int BIT_EN    = 15;
    localparam int BIT_PASS  = 16;

    localparam logic [31:0] SLOT_RESET = 32'h0000_1FFF;

    typedef logic [PID_W-1:0] pid_t;

    typedef struct packed {
        logic en;
        pid_t pid;
    } slot_t;

    typedef struct packed {
        logic pass_all;
        logic block_all;
        logic lsb_first;
    } gctl_t;

    function automatic logic [31:0] slot_wmask(input logic ctl_slot);
        return ctl_slot ? 32'h0001_FFFF : 32'h0000_9FFF;
    endfunction

    function automatic pid_t pid_from(input logic [7:0] hi, input logic [7:0] lo);
        return {hi[4:0], lo};
    endfunction

    function automatic logic [31:0] pack_word(input logic [7:0] a, input logic [7:0] b,
                                              input logic [7:0] c, input logic [7:0] d,
                                              input logic lsb_first);
        return lsb_first ? {d, c, b, a} : {a, b, c, d};
    endfunction

endpackage

// File: rtl/tsf_cfg_regs.sv
module tsf_cfg_regs import tsf_pkg::*; #(
    parameter int NUM_SLOTS = 8,
    parameter int AW = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [AW-1:0]                addr,
    input  logic [31:0]                  wdata,
    input  logic                         load,
    output logic [31:0]                  rdata,
    output slot_t [NUM_SLOTS-1:0]        slots,
    output gctl_t                        gctl
);
    localparam int SW = AW - 2;

    logic [NUM_SLOTS-1:0][31:0] shadow;
    logic [NUM_SLOTS-1:0][31:0] active;
    logic [SW-1:0]              sel;

    assign sel   = addr[AW-1:2];
    assign rdata = shadow[sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                shadow[i] <= SLOT_RESET;
                active[i] <= SLOT_RESET;
            end
        end else begin
            if (wr_en)
                shadow[sel] <= wdata & slot_wmask(sel == '0);
            if (load)
                active <= shadow;
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign slots[g].en  = active[g][BIT_EN];
        assign slots[g].pid = active[g][PID_W-1:0];
    end

    assign gctl.pass_all  = active[0][BIT_PASS];
    assign gctl.block_all = active[0][BIT_BLOCK];
    assign gctl.lsb_first = active[0][BIT_ORDER];

    // R8: the working copy only moves on a packet start
    assert_active_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(active));

endmodule

// File: rtl/tsf_pkt_track.sv
module tsf_pkt_track import tsf_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sop,
    output logic       take,
    output logic [7:0] idx
);
    localparam logic [7:0] LAST_IDX = 8'(PKT_BYTES - 1);

    logic       busy;
    logic [7:0] cnt;

    assign take = in_valid && (in_sop || busy);
    assign idx  = in_sop ? 8'd0 : cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= 8'd0;
        end else if (in_valid && in_sop) begin
            busy <= 1'b1;
            cnt  <= 8'd1;
        end else if (take) begin
            cnt <= cnt + 8'd1;
            if (cnt == LAST_IDX)
                busy <= 1'b0;
        end
    end

    // R11: inside a packet the position never runs past the last byte
    assert_count_range_R11: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt != 8'd0 && cnt <= LAST_IDX));

endmodule

// File: rtl/tsf_pid_match.sv
module tsf_pid_match import tsf_pkg::*; #(
    parameter int NUM_SLOTS = 8
) (
    input  slot_t [NUM_SLOTS-1:0] slots,
    input  gctl_t                 gctl,
    input  logic [7:0]            lead,
    input  pid_t                  pid,
    output logic                  keep
);
    logic [NUM_SLOTS-1:0] hit;
    logic                 sync_ok;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        assign hit[g] = slots[g].en && (slots[g].pid == pid);
    end

    assign sync_ok = (lead == SYNC_BYTE);
    assign keep    = sync_ok && (gctl.pass_all || (!gctl.block_all && (|hit)));

endmodule

// File: rtl/tsf_word_pack.sv
module tsf_word_pack import tsf_pkg::*; (
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  logic [7:0]  idx,
    input  logic [7:0]  data,
    input  logic        keep_now,
    input  logic        lsb_first,
    output logic [7:0]  lead_byte,
    output logic [7:0]  pid_byte,
    output logic        out_valid,
    output logic        out_sop,
    output logic [31:0] out_word
);
    logic       keep_q;
    logic [7:0] lane0, lane1, lane2;

    always_ff @(posedge clk) begin
        if (rst) begin
            keep_q    <= 1'b0;
            lead_byte <= 8'd0;
            pid_byte  <= 8'd0;
            lane0     <= 8'd0;
            lane1     <= 8'd0;
            lane2     <= 8'd0;
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_word  <= 32'd0;
        end else begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            if (take) begin
                if (idx == 8'd0) begin
                    lead_byte <= data;
                    keep_q    <= 1'b0;
                end else if (idx == 8'd1) begin
                    pid_byte <= data;
                end else if (idx == 8'd2) begin
                    keep_q <= keep_now;
                    lane0  <= lead_byte;
                    lane1  <= pid_byte;
                    lane2  <= data;
                end else if (keep_q) begin
                    case (idx[1:0])
                        2'd0: lane0 <= data;
                        2'd1: lane1 <= data;
                        2'd2: lane2 <= data;
                        default: begin
                            out_word  <= pack_word(lane0, lane1, lane2, data, lsb_first);
                            out_valid <= 1'b1;
                            out_sop   <= (idx == 8'd3);
                        end
                    endcase
                end
            end
        end
    end

    assert_sop_has_valid_R9: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> out_valid);

    assert_word_follows_byte_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(take));

    assert_sync_lead_R7: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> ((lsb_first ? out_word[7:0] : out_word[31:24]) == SYNC_BYTE));

endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter import tsf_pkg::*; #(
    parameter  int NUM_SLOTS = 8,
    localparam int CFG_AW    = $clog2(NUM_SLOTS) + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [7:0]        in_data,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              out_valid,
    output logic              out_sop,
    output logic [31:0]       out_word
);
    slot_t [NUM_SLOTS-1:0] slots;
    gctl_t                 gctl;
    logic                  take;
    logic [7:0]            idx;
    logic [7:0]            lead_byte;
    logic [7:0]            pid_byte;
    logic                  keep_now;
    logic                  pkt_load;

    assign pkt_load = in_valid && in_sop;

    tsf_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .AW(CFG_AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
        .load(pkt_load), .rdata(cfg_rdata), .slots(slots), .gctl(gctl)
    );

    tsf_pkt_track u_track (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
        .take(take), .idx(idx)
    );

    tsf_pid_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
        .slots(slots), .gctl(gctl), .lead(lead_byte),
        .pid(pid_from(pid_byte, in_data)), .keep(keep_now)
    );

    tsf_word_pack u_pack (
        .clk(clk), .rst(rst), .take(take), .idx(idx), .data(in_data),
        .keep_now(keep_now), .lsb_first(gctl.lsb_first),
        .lead_byte(lead_byte), .pid_byte(pid_byte),
        .out_valid(out_valid), .out_sop(out_sop), .out_word(out_word)
    );

endmodule

// File: tb/ts_pid_filter_tb_top.sv
module ts_pid_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic [7:0]  in_data = 8'd0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_addr = 5'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        out_valid;
    logic        out_sop;
    logic [31:0] out_word;

    int n_chk = 0;
    int n_err = 0;
    int seed  = 3;

    logic [31:0] m_shadow [8];
    logic [31:0] m_active [8];
    logic [12:0] slot_pid [8];

    bit          e_v = 0;
    bit          e_s = 0;
    logic [31:0] e_w = 32'd0;
    int          mism = 0;
    string       first_msg;

    always #4 clk = ~clk;   // 125 MHz

    ts_pid_filter dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .out_valid(out_valid), .out_sop(out_sop), .out_word(out_word)
    );

    function automatic logic [31:0] mmask(input int s);
        return (s == 0) ? 32'h0001_FFFF : 32'h0000_9FFF;
    endfunction

    function automatic bit m_keep(input logic [12:0] pid, input logic [7:0] lead);
        bit any = 0;
        for (int i = 0; i < 8; i++)
            if (m_active[i][15] && m_active[i][12:0] == pid) any = 1;
        if (lead != 8'h47) return 0;
        if (m_active[0][16]) return 1;
        if (m_active[0][13]) return 0;
        return any;
    endfunction

    task automatic step_check();
        if (out_valid !== e_v || (e_v && (out_sop !== e_s || out_word !== e_w))) begin
            if (mism == 0)
                first_msg = $sformatf("actual valid=%0b sop=%0b word=%h, expected valid=%0b sop=%0b word=%h",
                                      out_valid, out_sop, out_word, e_v, e_s, e_w);
            mism++;
        end
    endtask

    task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        step_check();
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        m_shadow[a[4:2]] = d & mmask(int'(a[4:2]));
        @(negedge clk);
        step_check();
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read_check(input string tag, input logic [4:0] a);
        logic [31:0] exp;
        @(negedge clk);
        cfg_addr = a;
        #1;
        exp = m_shadow[a[4:2]];
        n_chk++;
        if (cfg_rdata !== exp) begin
            n_err++;
            $display("FAIL %s readback addr=%h: actual %h expected %h", tag, a, cfg_rdata, exp);
        end
    endtask

    task automatic send_pkt(input string tag, input logic [12:0] pid, input logic [7:0] lead,
                            input bit gaps, input bit mid_en, input logic [4:0] mid_addr,
                            input logic [31:0] mid_data);
        logic [7:0] b [188];
        bit keep;
        bit lsb;
        for (int j = 0; j < 188; j++) begin
            if (j == 0)      b[j] = lead;
            else if (j == 1) b[j] = {3'b010, pid[12:8]};
            else if (j == 2) b[j] = pid[7:0];
            else             b[j] = 8'(j * 7 + seed);
        end
        seed = seed + 11;
        for (int i = 0; i < 8; i++) m_active[i] = m_shadow[i];
        keep = m_keep(pid, lead);
        lsb  = m_active[0][14];
        mism = 0;
        for (int j = 0; j < 188; j++) begin
            @(negedge clk);
            step_check();
            cfg_wr = 1'b0;
            in_valid = 1'b1; in_sop = (j == 0); in_data = b[j];
            if (mid_en && j == 100) begin
                cfg_wr = 1'b1; cfg_addr = mid_addr; cfg_wdata = mid_data;
                m_shadow[mid_addr[4:2]] = mid_data & mmask(int'(mid_addr[4:2]));
            end
            if (keep && (j % 4) == 3) begin
                e_v = 1; e_s = (j == 3);
                e_w = lsb ? {b[j], b[j-1], b[j-2], b[j-3]} : {b[j-3], b[j-2], b[j-1], b[j]};
            end else begin
                e_v = 0; e_s = 0;
            end
            if (gaps && (j % 3) == 1) begin
                @(negedge clk);
                step_check();
                cfg_wr = 1'b0;
                in_valid = 1'b0; in_sop = 1'b1; in_data = 8'hA5;   // R11: ignored cycle
                e_v = 0; e_s = 0;
            end
        end
        @(negedge clk);
        step_check();
        cfg_wr = 1'b0; in_valid = 1'b0; in_sop = 1'b0;
        e_v = 0; e_s = 0;
        @(negedge clk);
        step_check();
        n_chk++;
        if (mism != 0) begin
            n_err++;
            $display("FAIL %s pid=%h keep=%0b: %s", tag, pid, keep, first_msg);
        end
    endtask

    task automatic send_junk(input int n);
        mism = 0;
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            step_check();
            in_valid = 1'b1; in_sop = 1'b0; in_data = 8'h47;
            e_v = 0; e_s = 0;
        end
        @(negedge clk);
        step_check();
        in_valid = 1'b0;
        @(negedge clk);
        step_check();
        n_chk++;
        if (mism != 0) begin
            n_err++;
            $display("FAIL R11 stray bytes: %s", first_msg);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_shadow[i] = 32'h0000_1FFF;
            m_active[i] = 32'h0000_1FFF;
            slot_pid[i] = 13'(i * 1031 + 17);
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_err++;
            $display("FAIL R1 out_valid after reset: actual %b expected 0", out_valid);
        end
        for (int i = 0; i < 8; i++) cfg_read_check("R1", 5'(i * 4));
        send_pkt("R1", 13'h1FFF, 8'h47, 0, 0, 5'd0, 32'd0);
        send_pkt("R1", 13'h0000, 8'h47, 0, 0, 5'd0, 32'd0);

        // R2: field masks and address decode
        cfg_write(5'd12, 32'hFFFF_FFFF);
        cfg_read_check("R2", 5'd12);
        cfg_write(5'd0, 32'hFFFF_FFFF);
        cfg_read_check("R2", 5'd0);
        cfg_write(5'h1F, 32'h0000_8123);
        cfg_read_check("R2", 5'h1C);

        // R3: program every slot, sweep around each PID, both byte orders
        for (int i = 0; i < 8; i++) cfg_write(5'(i * 4), 32'h0000_8000 | 32'(slot_pid[i]));
        for (int o = 0; o < 2; o++) begin
            cfg_write(5'd0, 32'h0000_8000 | (o == 1 ? 32'h4000 : 32'h0) | 32'(slot_pid[0]));
            for (int i = 0; i < 8; i++) begin
                send_pkt("R3", slot_pid[i], 8'h47, 0, 0, 5'd0, 32'd0);
                send_pkt("R3", slot_pid[i] + 13'd1, 8'h47, 0, 0, 5'd0, 32'd0);
                send_pkt("R9", slot_pid[i] - 13'd1, 8'h47, 0, 0, 5'd0, 32'd0);
            end
        end

        // R4: parked and disabled slots
        cfg_write(5'd8, 32'h0000_1FFF);
        send_pkt("R4", slot_pid[2], 8'h47, 0, 0, 5'd0, 32'd0);
        send_pkt("R4", 13'h1FFF, 8'h47, 0, 0, 5'd0, 32'd0);
        cfg_write(5'd20, 32'(slot_pid[5]));
        send_pkt("R4", slot_pid[5], 8'h47, 0, 0, 5'd0, 32'd0);
        send_pkt("R3", slot_pid[6], 8'h47, 0, 0, 5'd0, 32'd0);

        // R6: block-all
        cfg_write(5'd0, 32'h0000_A000 | 32'(slot_pid[0]));
        send_pkt("R6", slot_pid[0], 8'h47, 0, 0, 5'd0, 32'd0);
        send_pkt("R6", slot_pid[1], 8'h47, 0, 0, 5'd0, 32'd0);

        // R5: forward-all beats block-all
        cfg_write(5'd0, 32'h0001_2000);
        send_pkt("R5", 13'h0ABC, 8'h47, 0, 0, 5'd0, 32'd0);
        send_pkt("R5", slot_pid[2], 8'h47, 0, 0, 5'd0, 32'd0);
        cfg_write(5'd0, 32'h0001_4000);
        send_pkt("R10", 13'h1FFF, 8'h47, 1, 0, 5'd0, 32'd0);
        send_pkt("R5", 13'h0001, 8'h47, 0, 0, 5'd0, 32'd0);

        // R7: bad sync dropped even with forward-all
        send_pkt("R7", slot_pid[3], 8'h46, 0, 0, 5'd0, 32'd0);
        send_pkt("R7", slot_pid[3], 8'hB8, 0, 0, 5'd0, 32'd0);
        send_pkt("R7", slot_pid[3], 8'h47, 0, 0, 5'd0, 32'd0);

        // R8: writes in the middle of a packet
        cfg_write(5'd0, 32'h0000_8000 | 32'(slot_pid[0]));
        send_pkt("R8", slot_pid[0], 8'h47, 0, 1, 5'd0, 32'h0000_E000 | 32'(slot_pid[0]));
        send_pkt("R8", slot_pid[0], 8'h47, 0, 0, 5'd0, 32'd0);
        cfg_write(5'd0, 32'h0000_8000 | 32'(slot_pid[0]));
        send_pkt("R8", slot_pid[1], 8'h47, 0, 1, 5'd4, 32'h0000_1FFF);
        send_pkt("R8", slot_pid[1], 8'h47, 0, 0, 5'd0, 32'd0);
        send_pkt("R8", slot_pid[0], 8'h47, 1, 1, 5'd0, 32'h0000_C000 | 32'(slot_pid[0]));
        send_pkt("R9", slot_pid[0], 8'h47, 0, 0, 5'd0, 32'd0);

        // R11: stray bytes between packets and gapped packets
        send_junk(9);
        send_pkt("R11", slot_pid[7], 8'h47, 1, 0, 5'd0, 32'd0);
        send_junk(4);
        send_pkt("R10", slot_pid[4], 8'h47, 0, 0, 5'd0, 32'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule